// File: doc/BRIEF.md
# Pixel Format Converter with Alpha Control

The block takes a stream of pixels in one of several packed input layouts and turns each one into a 32-bit ARGB word with 8 bits per channel. In direct-colour layouts every narrow channel is widened to 8 bits. The widening repeats the top bits of the field into the freed low bits, so a field of all ones becomes 0xFF and a field of zero stays 0x00. In the indexed layout the low byte of the pixel is an address into a colour lookup table held outside the block. The block drives a read port on that table and takes the 32-bit ARGB entry that comes back one cycle later.

After the colour has been formed, the alpha byte is kept as it is, replaced by a programmed constant, or scaled by that constant. Layouts that carry no alpha get 0xFF before this step. Both edges of the block use a valid/ready handshake. Pixels leave in the order they entered, and none is lost or repeated while the output is stalled. The configuration inputs must stay steady while pixels are inside the block.

Top module: `pix_fmt_conv`

## Requirements
- R1: During and right after reset, `outValid` and `clutRdEn` are 0 and `inReady` is 1.
- R2: Format code 0 (and the unused codes 6 and 7) passes the 32-bit input through unchanged, with alpha in [31:24], red in [23:16], green in [15:8] and blue in [7:0].
- R3: Format code 1 takes red, green and blue from bits [23:16], [15:8] and [7:0], and sets alpha to 0xFF.
- R4: Format code 2 takes a 5-bit red from [15:11], a 6-bit green from [10:5] and a 5-bit blue from [4:0]. Each is widened by repeating its top bits into the low bits, and alpha is 0xFF.
- R5: Format code 3 takes alpha from bit 15 (1 gives 0xFF, 0 gives 0x00) and 5-bit red, green and blue from [14:10], [9:5] and [4:0], each widened by bit repetition.
- R6: Format code 4 takes 4-bit alpha, red, green and blue from [15:12], [11:8], [7:4] and [3:0]. Each nibble is written twice to form a byte.
- R7: Format code 5 raises `clutRdEn` in the cycle an input pixel is accepted, with `clutRdAddr` equal to `inPixel[7:0]`. The pixel's colour and alpha are the `clutRdData` word present in the following cycle.
- R8: Alpha mode 0 (and unused mode 3) keeps the alpha that was formed. Mode 1 replaces it with `cfgAlphaVal`.
- R9: Alpha mode 2 sets alpha to floor(alpha × `cfgAlphaVal` / 255). The colour channels are left unchanged.
- R10: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outPixel` holds its value. Every accepted pixel is delivered exactly once and in input order, including when direct and indexed pixels are mixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input pixel present |
| inReady | output | 1 | Block takes the input pixel at this edge |
| inPixel | input | 32 | Packed input pixel |
| cfgFormat | input | 3 | Input layout code (0 to 5) |
| cfgAlphaMode | input | 2 | 0 keep, 1 replace, 2 scale |
| cfgAlphaVal | input | 8 | Constant used by alpha modes 1 and 2 |
| clutRdEn | output | 1 | Lookup table read strobe |
| clutRdAddr | output | IDX_W | Lookup table read address |
| clutRdData | input | 32 | Lookup table entry, valid one cycle after the strobe |
| outValid | output | 1 | Output pixel present |
| outReady | input | 1 | Consumer takes the output pixel at this edge |
| outPixel | output | 32 | Converted ARGB pixel |

## Verification
Each direct layout is driven with all-ones and all-zero fields, and with fields whose top and bottom bits differ. The extreme fields show that a converter pads with replicated bits rather than zeros. The mixed fields reveal a field taken from the wrong slice or a swapped channel. Alpha scaling is tried at zero, at full scale and at mid values whose product is not a multiple of 255, so a rounding or off-by-one divider shows up. A run of indexed pixels is mixed with direct ones under a pseudo-random stall pattern on the output, which shows whether the one-cycle table latency ever lets pixels reorder, drop or repeat.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [2:0] {
    FMT_ARGB8888 = 3'd0,
    FMT_RGB888   = 3'd1,
    FMT_RGB565   = 3'd2,
    FMT_ARGB1555 = 3'd3,
    FMT_ARGB4444 = 3'd4,
    FMT_L8       = 3'd5
  } pix_fmt_e;

  typedef enum logic [1:0] {
    ALPHA_KEEP  = 2'd0,
    ALPHA_SET   = 2'd1,
    ALPHA_SCALE = 2'd2
  } alpha_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadS1;   // capture a new input pixel
    logic lutFill;  // overwrite stage 1 with the table word
    logic loadS2;   // move stage 1 into the output register
  } pfc_strobe_t;

  function automatic logic [7:0] widen5(logic [4:0] f);
    return {f, f[4:2]};
  endfunction

  function automatic logic [7:0] widen6(logic [5:0] f);
    return {f, f[5:4]};
  endfunction

  function automatic logic [7:0] widen4(logic [3:0] f);
    return {f, f};
  endfunction

  function automatic logic [31:0] expandDirect(logic [2:0] fmt, logic [31:0] p);
    logic [31:0] res;
    case (fmt)
      FMT_RGB888:   res = {8'hFF, p[23:0]};
      FMT_RGB565:   res = {8'hFF, widen5(p[15:11]), widen6(p[10:5]), widen5(p[4:0])};
      FMT_ARGB1555: res = {{8{p[15]}}, widen5(p[14:10]), widen5(p[9:5]), widen5(p[4:0])};
      FMT_ARGB4444: res = {widen4(p[15:12]), widen4(p[11:8]), widen4(p[7:4]), widen4(p[3:0])};
      default:      res = p;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pfc_ctrl.sv
module pfc_ctrl
  import pfc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        isIndexed,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output logic        clutRdEn,
  output pfc_strobe_t ctl
);

  logic s1Valid, s1NeedLut, s2Valid;
  logic s2Free, s1Move, accept;

  assign s2Free  = !s2Valid || outReady;
  assign s1Move  = s1Valid && !s1NeedLut && s2Free;
  assign inReady = !s1Valid || s1Move;
  assign accept  = inValid && inReady;

  assign clutRdEn    = accept && isIndexed;
  assign ctl.loadS1  = accept;
  assign ctl.lutFill = s1NeedLut;
  assign ctl.loadS2  = s1Move;
  assign outValid    = s2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      s1NeedLut <= 1'b0;
      s2Valid   <= 1'b0;
    end else begin
      if (accept)      s1Valid <= 1'b1;
      else if (s1Move) s1Valid <= 1'b0;
      s1NeedLut <= accept && isIndexed;
      if (s1Move)        s2Valid <= 1'b1;
      else if (outReady) s2Valid <= 1'b0;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R7
  lut_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    clutRdEn |=> !inReady || !s1Valid || ctl.lutFill);

endmodule

// File: rtl/pfc_datapath.sv
module pfc_datapath
  import pfc_pkg::*;
#(
  parameter int PIX_W       = 32,
  parameter bit USE_DIVIDER = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  pfc_strobe_t      ctl,
  input  logic [PIX_W-1:0] inPixel,
  input  logic [2:0]       cfgFormat,
  input  logic [1:0]       cfgAlphaMode,
  input  logic [7:0]       cfgAlphaVal,
  input  logic [PIX_W-1:0] clutRdData,
  output logic [PIX_W-1:0] outPixel
);

  localparam int CH_W   = PIX_W / 4;
  localparam int PROD_W = 2 * CH_W;

  logic [PIX_W-1:0]  s1Data, s2Data;
  logic [CH_W-1:0]   alphaIn, alphaScaled, alphaNew;
  logic [PROD_W-1:0] prod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Data <= '0;
    end else if (ctl.loadS1) begin
      s1Data <= expandDirect(cfgFormat, inPixel);
    end else if (ctl.lutFill) begin
      s1Data <= clutRdData;
    end
  end

  assign alphaIn = s1Data[PIX_W-1 -: CH_W];
  assign prod    = alphaIn * cfgAlphaVal;

  generate
    if (USE_DIVIDER) begin : g_div
      logic [PROD_W-1:0] quot;
      assign quot        = prod / PROD_W'(255);
      assign alphaScaled = quot[CH_W-1:0];
    end else begin : g_shift
      logic [PROD_W:0] sum;
      assign sum         = {1'b0, prod} + {{(CH_W+1){1'b0}}, prod[PROD_W-1:CH_W]} + 1'b1;
      assign alphaScaled = sum[PROD_W-1:CH_W];
    end
  endgenerate

  always_comb begin
    case (cfgAlphaMode)
      ALPHA_SET:   alphaNew = cfgAlphaVal;
      ALPHA_SCALE: alphaNew = alphaScaled;
      default:     alphaNew = alphaIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Data <= '0;
    end else if (ctl.loadS2) begin
      s2Data <= {alphaNew, s1Data[PIX_W-CH_W-1:0]};
    end
  end

  assign outPixel = s2Data;

  // R8
  alpha_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadS2 && cfgAlphaMode == ALPHA_SET |=> outPixel[PIX_W-1 -: CH_W] == $past(cfgAlphaVal));

  // R9
  alpha_scale_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadS2 && cfgAlphaMode == ALPHA_SCALE |=> outPixel[PIX_W-1 -: CH_W] <= $past(cfgAlphaVal));

endmodule

// File: rtl/pix_fmt_conv.sv
module pix_fmt_conv
  import pfc_pkg::*;
#(
  parameter int IDX_W       = 8,
  parameter bit USE_DIVIDER = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [31:0]      inPixel,
  input  logic [2:0]       cfgFormat,
  input  logic [1:0]       cfgAlphaMode,
  input  logic [7:0]       cfgAlphaVal,
  output logic             clutRdEn,
  output logic [IDX_W-1:0] clutRdAddr,
  input  logic [31:0]      clutRdData,
  output logic             outValid,
  input  logic             outReady,
  output logic [31:0]      outPixel
);

  pfc_strobe_t ctl;
  logic        isIndexed;

  assign isIndexed  = (cfgFormat == FMT_L8);
  assign clutRdAddr = inPixel[IDX_W-1:0];

  pfc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .isIndexed(isIndexed),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .clutRdEn (clutRdEn),
    .ctl      (ctl)
  );

  pfc_datapath #(.PIX_W(32), .USE_DIVIDER(USE_DIVIDER)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .inPixel     (inPixel),
    .cfgFormat   (cfgFormat),
    .cfgAlphaMode(cfgAlphaMode),
    .cfgAlphaVal (cfgAlphaVal),
    .clutRdData  (clutRdData),
    .outPixel    (outPixel)
  );

  // R10
  out_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outPixel));

  // R7
  lut_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    clutRdEn |-> inValid && inReady && cfgFormat == FMT_L8);

  // R3
  no_alpha_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && cfgAlphaMode == ALPHA_KEEP && (cfgFormat == FMT_RGB888 || cfgFormat == FMT_RGB565)
    |-> outPixel[31:24] == 8'hFF);

endmodule

// File: tb/tb_pix_fmt_conv.sv
`timescale 1ns/1ps
module tb_pix_fmt_conv;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inPixel = '0;
  logic [2:0]  cfgFormat = '0;
  logic [1:0]  cfgAlphaMode = '0;
  logic [7:0]  cfgAlphaVal = '0;
  logic        clutRdEn;
  logic [7:0]  clutRdAddr;
  logic [31:0] clutRdData = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outPixel;

  int total = 0;
  int bad   = 0;
  string curReq = "R1";
  logic [31:0] expQ[$];
  logic        prevStall = 1'b0;
  logic [31:0] prevPix = '0;

  always #2.5 clk = ~clk;

  pix_fmt_conv dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inPixel(inPixel),
    .cfgFormat(cfgFormat), .cfgAlphaMode(cfgAlphaMode), .cfgAlphaVal(cfgAlphaVal),
    .clutRdEn(clutRdEn), .clutRdAddr(clutRdAddr), .clutRdData(clutRdData),
    .outValid(outValid), .outReady(outReady), .outPixel(outPixel)
  );

  function automatic logic [31:0] lutWord(logic [7:0] i);
    return {i ^ 8'hA5, ~i, i + 8'd7, i};
  endfunction

  // table with one cycle read latency
  always @(posedge clk) if (clutRdEn) clutRdData <= lutWord(clutRdAddr);

  function automatic logic [31:0] refPix(int fmt, logic [31:0] p, int am, logic [7:0] av);
    logic [7:0] a, r, g, b;
    int prod;
    {a, r, g, b} = p;
    case (fmt)
      1: a = 8'hFF;
      2: begin
        a = 8'hFF;
        r = {p[15:11], p[15:13]};
        g = {p[10:5], p[10:9]};
        b = {p[4:0], p[4:2]};
      end
      3: begin
        a = p[15] ? 8'hFF : 8'h00;
        r = {p[14:10], p[14:12]};
        g = {p[9:5], p[9:7]};
        b = {p[4:0], p[4:2]};
      end
      4: begin
        a = {2{p[15:12]}}; r = {2{p[11:8]}}; g = {2{p[7:4]}}; b = {2{p[3:0]}};
      end
      5: {a, r, g, b} = lutWord(p[7:0]);
      default: ;
    endcase
    prod = int'(a) * int'(av);
    if (am == 1) a = av;
    else if (am == 2) a = 8'(prod / 255);
    return {a, r, g, b};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // output monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) check("R10", {outValid, outPixel}, {1'b1, prevPix});
      if (outValid && outReady) begin
        if (expQ.size() == 0) check(curReq, {1'b1, outPixel}, 33'h0);
        else check(curReq, outPixel, expQ.pop_front());
      end
      prevStall = outValid && !outReady;
      prevPix   = outPixel;
    end
  end

  // tasks start right after a rising edge
  task automatic sendPix(logic [31:0] p);
    logic acc;
    inValid = 1'b1;
    inPixel = p;
    do begin
      @(negedge clk);
      acc = inReady;
      if (acc) begin
        expQ.push_back(refPix(cfgFormat, p, cfgAlphaMode, cfgAlphaVal));
        if (cfgFormat == 3'd5) check("R7", {clutRdEn, 24'h0, clutRdAddr}, {1'b1, 24'h0, p[7:0]});
        else                   check("R7", {31'h0, clutRdEn}, 32'h0);
      end
      @(posedge clk); #1;
    end while (!acc);
  endtask

  task automatic drain();
    inValid = 1'b0;
    for (int i = 0; i < 200 && expQ.size() != 0; i++) begin
      @(posedge clk); #1;
    end
    if (expQ.size() != 0) check(curReq, 32'(expQ.size()), 32'h0);
    @(posedge clk); #1;
  endtask

  task automatic setCfg(int fmt, int am, logic [7:0] av, string req);
    cfgFormat = 3'(fmt); cfgAlphaMode = 2'(am); cfgAlphaVal = av; curReq = req;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", {29'h0, outValid, inReady, clutRdEn}, {29'h0, 1'b0, 1'b1, 1'b0});
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {29'h0, outValid, inReady, clutRdEn}, {29'h0, 1'b0, 1'b1, 1'b0});
    @(posedge clk); #1;
  endtask

  task automatic testPassThrough();
    setCfg(0, 0, 8'h00, "R2");
    sendPix(32'h12345678); sendPix(32'hFF00A55A); sendPix(32'h00000000);
    drain();
    setCfg(7, 0, 8'h00, "R2");
    sendPix(32'hDEADBEEF);
    drain();
  endtask

  task automatic testRgb888();
    setCfg(1, 0, 8'h00, "R3");
    sendPix(32'h00112233); sendPix(32'h7FFEDCBA);
    drain();
  endtask

  task automatic testRgb565();
    setCfg(2, 0, 8'h00, "R4");
    sendPix(32'h0000FFFF); sendPix(32'h00000000); sendPix(32'hABCD8421); sendPix(32'h0000F81F);
    drain();
  endtask

  task automatic testArgb1555();
    setCfg(3, 0, 8'h00, "R5");
    sendPix(32'h0000FFFF); sendPix(32'h00007FFF); sendPix(32'h00008000); sendPix(32'h0000C631);
    drain();
  endtask

  task automatic testArgb4444();
    setCfg(4, 0, 8'h00, "R6");
    sendPix(32'h0000F0A5); sendPix(32'h00001234); sendPix(32'h0000FFFF);
    drain();
  endtask

  task automatic testIndexed();
    setCfg(5, 0, 8'h00, "R7");
    sendPix(32'h00000000); sendPix(32'h000000FF); sendPix(32'hFFFF0042); sendPix(32'h00000081);
    drain();
  endtask

  task automatic testAlpha();
    setCfg(0, 1, 8'h3C, "R8");
    sendPix(32'h80102030); sendPix(32'h00ABCDEF);
    drain();
    setCfg(2, 1, 8'h00, "R8");
    sendPix(32'h0000FFFF);
    drain();
    setCfg(0, 3, 8'h11, "R8");
    sendPix(32'h5A010203);
    drain();
    setCfg(0, 2, 8'h80, "R9");
    sendPix(32'h80010203); sendPix(32'h00FFFFFF); sendPix(32'hFF000000); sendPix(32'h7F445566);
    drain();
    setCfg(0, 2, 8'hFF, "R9");
    sendPix(32'hC3000000); sendPix(32'h01000000);
    drain();
    setCfg(4, 2, 8'h33, "R9");
    sendPix(32'h0000E123);
    drain();
  endtask

  task automatic testBackpressure();
    logic [15:0] lfsr = 16'hACE1;
    bit done = 1'b0;
    setCfg(5, 2, 8'hC8, "R10");
    fork
      begin
        for (int i = 0; i < 24; i++) sendPix(32'(i * 37 + 5));
        done = 1'b1;
      end
      begin
        while (!done) begin
          @(posedge clk); #1;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          outReady = lfsr[0] | lfsr[3];
        end
      end
    join
    inValid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      outReady = 1'b0;
    end
    outReady = 1'b1;
    drain();
    setCfg(3, 0, 8'h00, "R10");
    outReady = 1'b0;
    sendPix(32'h00001111); sendPix(32'h00009999);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
    end
    outReady = 1'b1;
    drain();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    testReset();
    testPassThrough();
    testRgb888();
    testRgb565();
    testArgb1555();
    testArgb4444();
    testIndexed();
    testAlpha();
    testBackpressure();
    summary();
  end

endmodule